// File: doc/BRIEF.md
# Look-aside Write-back Second-level Cache

This block is a second-level cache controller that sits beside main memory. The first-level cache sends it two kinds of request: line reads, and single-byte writes. Each request reaches this cache and main memory at the same moment. The cache looks up the line while memory begins a line read. On a hit the cache tells memory to drop that read, and it answers from its own storage. On a miss it waits for the memory line, installs it, and sends the same line back up to the requester so the upper level can fill as well.

Storage is set-associative. The defaults are 8 ways, 128 sets and 32-byte lines, for 32 KB in total. The line offset comes from the low address bits, the set index from the bits just above them, and the tag from the remainder. Writes change only the cached copy and mark the line dirty. Memory sees a write only when a dirty line is chosen as a victim, and that write-back completes before the new line overwrites the way. Victims are chosen in FIFO order within each set, using a per-set pointer. Empty ways are used before the pointer is consulted. The block handles one request at a time.

Top module: `lookaside_wb_cache`

## Requirements
- R1: After reset every line is invalid and every set's FIFO pointer is zero. `up_busy`, `up_done`, `mem_rd_req` and `mem_wr_req` are low, and the first access to any address is a miss.
- R2: An access whose tag matches a valid way of the indexed set reports `up_hit`=1. It returns the cached line on `up_rline`, with a write's byte already merged in.
- R3: In the cycle after acceptance, every request drives `mem_rd_req` for exactly one cycle with the line-aligned address. On a hit, `mem_abort` is high in that same cycle and no memory data is used.
- R4: A write stores `up_wbyte` at bits [8*off+7 : 8*off] of the line, where off = `up_addr`[4:0], and sets the line's dirty flag. A write never causes a memory write of its own line.
- R5: On a miss, the line returned on `mem_rd_data` is installed, with a write's byte merged in. The same line is returned on `up_rline` with `up_hit`=0.
- R6: On a miss, the lowest-numbered invalid way is filled first. When the set is full, the way at the set's FIFO pointer is filled. The pointer advances by one, modulo the number of ways, on every fill. Hits never change it.
- R7: Evicting a dirty victim produces exactly one memory write, carrying the victim's own line address and its current contents, before the refill. Evicting a clean victim produces no memory write.
- R8: Once raised, `mem_wr_req` stays high with a stable `mem_wr_addr` until `mem_wr_ack` is seen.
- R9: `up_busy` is high from the cycle after acceptance until the end of the response. `up_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upper-level request, accepted when not busy |
| up_we | input | 1 | 1 = byte write, 0 = line read |
| up_addr | input | ADDR_W | Byte address of the request |
| up_wbyte | input | 8 | Byte to write |
| up_busy | output | 1 | A request is in progress |
| up_done | output | 1 | Response valid, one cycle |
| up_hit | output | 1 | Response came from the cache |
| up_rline | output | 8*LINE_BYTES | Line returned to the upper level |
| mem_rd_req | output | 1 | Parallel memory line read, one cycle |
| mem_abort | output | 1 | Cancels the read issued in the same cycle |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 8*LINE_BYTES | Memory read line |
| mem_wr_req | output | 1 | Dirty victim write-back request |
| mem_wr_addr | output | ADDR_W | Line-aligned write-back address |
| mem_wr_data | output | 8*LINE_BYTES | Write-back line |
| mem_wr_ack | input | 1 | Memory accepted the write-back |

## Verification
The hardest case to reach from the ports is a dirty victim chosen by the FIFO pointer. It needs a write to land in a way, and then enough distinct tags in that one set to wrap the pointer back to it. Hits in between must leave the order untouched. Before the random sweep, the bench brings the design to this state by mapping nine or more tags onto a single set. The sweep then draws tags from a pool only slightly larger than the associativity, which keeps evictions of dirty lines frequent. The memory read returns while the write-back is still waiting for its acknowledge, so the design must hold the early read data until the refill.

// File: rtl/lacache_pkg.sv
package lacache_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOOK  = 3'd1,
      ST_EVICT = 3'd2,
      ST_FILL  = 3'd3,
      ST_RESP  = 3'd4
   } lc_state_e;
endpackage

// File: rtl/lacache_hit.sv
module lacache_hit #(
   parameter int TAG_W = 20,
   parameter int WAYS  = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
   input  logic [WAYS-1:0]            way_valid,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tags[w] == look_tag);
   end

   always_comb begin
      hit     = |match;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/lacache_victim.sv
module lacache_victim #(
   parameter int WAYS = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  way_valid,
   input  logic [WAY_W-1:0] fifo_ptr,
   output logic [WAY_W-1:0] victim
);
   logic found;

   always_comb begin
      victim = fifo_ptr;
      found  = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!way_valid[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lacache_fifo.sv
module lacache_fifo #(
   parameter int SETS = 128,
   parameter int WAYS = 8,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_set,
   input  logic             adv,
   input  logic [IDX_W-1:0] adv_set,
   output logic [WAY_W-1:0] ptr
);
   logic [WAY_W-1:0] ptr_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (adv) begin
         ptr_q[adv_set] <= ptr_q[adv_set] + 1'b1;
      end
   end

   assign ptr = ptr_q[rd_set];
endmodule

// File: rtl/lookaside_wb_cache.sv
module lookaside_wb_cache
   import lacache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int WAYS       = 8,
   parameter int SETS       = 128,
   localparam int LINE_W    = 8 * LINE_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic              up_we,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [7:0]        up_wbyte,
   output logic              up_busy,
   output logic              up_done,
   output logic              up_hit,
   output logic [LINE_W-1:0] up_rline,
   output logic              mem_rd_req,
   output logic              mem_abort,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [LINE_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [LINE_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int IDX_W   = $clog2(SETS);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
   localparam int ENT_W   = IDX_W + WAY_W;
   localparam int ENTRIES = SETS * WAYS;

   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != SETS || (1 << WAY_W) != WAYS)
   begin : g_bad_pow2
      $error("line size, set count and way count must be powers of two");
   end
   if (WAYS < 2 || TAG_W < 1) begin : g_bad_geom
      $error("need at least two ways and one tag bit");
   end

   function automatic logic [LINE_W-1:0] put_byte(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off,
                                                  input logic [7:0]        val);
      logic [LINE_W-1:0] res;
      res = line;
      res[{off, 3'b000} +: 8] = val;
      return res;
   endfunction

   lc_state_e         state_q;
   logic              req_we_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [7:0]        req_byte_q;
   logic [WAY_W-1:0]  vic_way_q;
   logic              got_q;
   logic [LINE_W-1:0] buf_q;
   logic [LINE_W-1:0] rline_q;
   logic              hit_q;

   logic [TAG_W-1:0]  tag_q  [ENTRIES];
   logic [LINE_W-1:0] data_q [ENTRIES];
   logic [SETS-1:0][WAYS-1:0] valid_q;
   logic [SETS-1:0][WAYS-1:0] dirty_q;

   logic [OFF_W-1:0] r_off;
   logic [IDX_W-1:0] r_set;
   logic [TAG_W-1:0] r_tag;
   assign r_off = req_addr_q[OFF_W-1:0];
   assign r_set = req_addr_q[OFF_W +: IDX_W];
   assign r_tag = req_addr_q[ADDR_W-1 -: TAG_W];

   logic [WAYS-1:0][TAG_W-1:0] set_tags;
   always_comb begin
      for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[{r_set, WAY_W'(w)}];
   end

   logic             hit;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim;
   logic [WAY_W-1:0] fifo_ptr;

   lacache_hit #(.TAG_W(TAG_W), .WAYS(WAYS)) u_hit (
      .way_tags (set_tags),
      .way_valid(valid_q[r_set]),
      .look_tag (r_tag),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   lacache_victim #(.WAYS(WAYS)) u_victim (
      .way_valid(valid_q[r_set]),
      .fifo_ptr (fifo_ptr),
      .victim   (victim)
   );

   logic look_hit;
   logic fill_now;
   assign look_hit = (state_q == ST_LOOK) && hit;
   assign fill_now = (state_q == ST_FILL) && (got_q || mem_rd_valid);

   lacache_fifo #(.SETS(SETS), .WAYS(WAYS)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (r_set),
      .adv    (fill_now),
      .adv_set(r_set),
      .ptr    (fifo_ptr)
   );

   logic [ENT_W-1:0]  hit_ent;
   logic [ENT_W-1:0]  vic_ent;
   logic [LINE_W-1:0] hit_line;
   logic [LINE_W-1:0] fill_line;
   logic [LINE_W-1:0] new_line;
   assign hit_ent   = {r_set, hit_way};
   assign vic_ent   = {r_set, vic_way_q};
   assign hit_line  = req_we_q ? put_byte(data_q[hit_ent], r_off, req_byte_q) : data_q[hit_ent];
   assign fill_line = got_q ? buf_q : mem_rd_data;
   assign new_line  = req_we_q ? put_byte(fill_line, r_off, req_byte_q) : fill_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_we_q   <= 1'b0;
         req_addr_q <= '0;
         req_byte_q <= '0;
         vic_way_q  <= '0;
         got_q      <= 1'b0;
         buf_q      <= '0;
         rline_q    <= '0;
         hit_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (up_req) begin
                  req_we_q   <= up_we;
                  req_addr_q <= up_addr;
                  req_byte_q <= up_wbyte;
                  state_q    <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               got_q <= 1'b0;
               hit_q <= hit;
               if (hit) begin
                  rline_q <= hit_line;
                  state_q <= ST_RESP;
               end else begin
                  vic_way_q <= victim;
                  state_q   <= (valid_q[r_set][victim] && dirty_q[r_set][victim])
                               ? ST_EVICT : ST_FILL;
               end
            end
            ST_EVICT: begin
               if (mem_rd_valid) begin
                  buf_q <= mem_rd_data;
                  got_q <= 1'b1;
               end
               if (mem_wr_ack) state_q <= ST_FILL;
            end
            ST_FILL: begin
               if (fill_now) begin
                  rline_q <= new_line;
                  state_q <= ST_RESP;
               end
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (look_hit && req_we_q) data_q[hit_ent] <= hit_line;
      if (fill_now) begin
         data_q[vic_ent] <= new_line;
         tag_q[vic_ent]  <= r_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (look_hit && req_we_q) dirty_q[r_set][hit_way] <= 1'b1;
         if (fill_now) begin
            valid_q[r_set][vic_way_q] <= 1'b1;
            dirty_q[r_set][vic_way_q] <= req_we_q;
         end
      end
   end

   assign up_busy     = (state_q != ST_IDLE);
   assign up_done     = (state_q == ST_RESP);
   assign up_hit      = hit_q;
   assign up_rline    = rline_q;
   assign mem_rd_req  = (state_q == ST_LOOK);
   assign mem_abort   = look_hit;
   assign mem_rd_addr = {req_addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
   assign mem_wr_req  = (state_q == ST_EVICT);
   assign mem_wr_addr = {tag_q[vic_ent], r_set, OFF_W'(0)};
   assign mem_wr_data = data_q[vic_ent];
endmodule

// File: rtl/lacache_chk.sv
module lacache_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_req,
   input logic              up_busy,
   input logic              up_done,
   input logic              mem_rd_req,
   input logic              mem_abort,
   input logic              mem_wr_req,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              mem_wr_ack
);
   a_r3_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && !up_busy) |=> mem_rd_req);
   a_r3_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);
   a_r3_abort_only_with_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |-> mem_rd_req);
   a_r4_no_writeback_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |=> !mem_wr_req);
   a_r8_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      up_done |=> !up_done);
   a_r9_mem_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || mem_wr_req) |-> up_busy);
endmodule

bind lookaside_wb_cache lacache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .up_req     (up_req),
   .up_busy    (up_busy),
   .up_done    (up_done),
   .mem_rd_req (mem_rd_req),
   .mem_abort  (mem_abort),
   .mem_wr_req (mem_wr_req),
   .mem_wr_addr(mem_wr_addr),
   .mem_wr_ack (mem_wr_ack)
);

// File: tb/lookaside_wb_cache_test.sv
module lookaside_wb_cache_test;
   localparam int CLK_NS = 10;
   localparam int AW     = 16;
   localparam int LB     = 32;
   localparam int NW     = 8;
   localparam int NS     = 4;
   localparam int LW     = 8 * LB;
   localparam int NLINES = 1 << (AW - 5);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_req = 1'b0;
   logic          up_we = 1'b0;
   logic [AW-1:0] up_addr = '0;
   logic [7:0]    up_wbyte = '0;
   logic          up_busy, up_done, up_hit;
   logic [LW-1:0] up_rline;
   logic          mem_rd_req, mem_abort, mem_wr_req;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic          mem_rd_valid;
   logic [LW-1:0] mem_rd_data;
   logic [LW-1:0] mem_wr_data;
   logic          mem_wr_ack;

   always #(CLK_NS / 2) clk = ~clk;

   lookaside_wb_cache #(.ADDR_W(AW), .LINE_BYTES(LB), .WAYS(NW), .SETS(NS)) uut (
      .clk(clk), .rst_n(rst_n),
      .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wbyte(up_wbyte),
      .up_busy(up_busy), .up_done(up_done), .up_hit(up_hit), .up_rline(up_rline),
      .mem_rd_req(mem_rd_req), .mem_abort(mem_abort), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   logic [LW-1:0] mem_a [NLINES];
   logic [LW-1:0] gold  [NLINES];
   logic [8:0]    mtag   [NS][NW];
   bit            mval   [NS][NW];
   bit            mdirty [NS][NW];
   int            mptr   [NS];

   int n_chk = 0, n_bad = 0;
   int ab_cnt = 0, rd_cnt = 0, wb_cnt = 0;
   int exp_hits = 0, exp_miss = 0;
   logic [AW-1:0] last_wb_addr = '0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural memory: read latency 3 negedges, write ack after 3 cycles held
   initial begin
      int rd_cd = 0;
      int wr_wait = 0;
      logic [LW-1:0] rd_line = '0;
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
      mem_wr_ack   = 1'b0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         mem_wr_ack   = 1'b0;
         if (rd_cd > 0) begin
            rd_cd--;
            if (rd_cd == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = rd_line;
            end
         end
         if (rst_n && mem_rd_req) begin
            if (mem_abort) ab_cnt++;
            else begin
               rd_cnt++;
               rd_line = mem_a[mem_rd_addr[AW-1:5]];
               rd_cd = 3;
            end
         end
         if (rst_n && mem_wr_req) begin
            wr_wait++;
            if (wr_wait == 3) begin
               mem_a[mem_wr_addr[AW-1:5]] = mem_wr_data;
               last_wb_addr = mem_wr_addr;
               wb_cnt++;
               mem_wr_ack = 1'b1;
               wr_wait = 0;
            end
         end else wr_wait = 0;
      end
   end

   task automatic access(input bit we, input logic [AW-1:0] a, input logic [7:0] b);
      int line = int'(a[AW-1:5]);
      int st = int'(a[6:5]);
      logic [8:0] tg = a[AW-1:7];
      int off = int'(a[4:0]);
      bit ehit = 1'b0;
      int way = 0;
      bit ewb = 1'b0;
      logic [AW-1:0] ewb_addr = '0;
      int wb0 = wb_cnt, ab0 = ab_cnt, rd0 = rd_cnt;
      logic [LW-1:0] mem_pre = mem_a[line];
      int guard = 0;
      for (int w = 0; w < NW; w++) begin
         if (mval[st][w] && mtag[st][w] == tg && !ehit) begin
            ehit = 1'b1;
            way = w;
         end
      end
      if (!ehit) begin
         bit f = 1'b0;
         way = mptr[st];
         for (int w = 0; w < NW; w++) begin
            if (!mval[st][w] && !f) begin
               way = w;
               f = 1'b1;
            end
         end
         if (mval[st][way] && mdirty[st][way]) begin
            ewb = 1'b1;
            ewb_addr = {mtag[st][way], a[6:5], 5'd0};
         end
      end
      @(negedge clk);
      up_req = 1'b1; up_we = we; up_addr = a; up_wbyte = b;
      @(negedge clk);
      up_req = 1'b0;
      chk(up_busy == 1'b1, "R9", "busy after accept", LW'(up_busy), LW'(1));
      while (!up_done && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(up_done == 1'b1, "R9", "response arrives", LW'(up_done), LW'(1));
      if (we) gold[line][off*8 +: 8] = b;
      chk(up_hit == ehit, ehit ? "R2" : "R6", "hit flag", LW'(up_hit), LW'(ehit));
      chk(up_rline == gold[line], ehit ? "R2" : "R5", "returned line", up_rline, gold[line]);
      chk(ab_cnt - ab0 == int'(ehit), "R3", "memory read cancelled on hit",
          LW'(ab_cnt - ab0), LW'(ehit));
      chk(rd_cnt - rd0 == int'(!ehit), "R3", "memory read used on miss",
          LW'(rd_cnt - rd0), LW'(!ehit));
      chk(wb_cnt - wb0 == int'(ewb), "R7", "write-back count", LW'(wb_cnt - wb0), LW'(ewb));
      if (ewb) begin
         chk(last_wb_addr == ewb_addr, "R7", "write-back address", LW'(last_wb_addr), LW'(ewb_addr));
         chk(mem_a[ewb_addr[AW-1:5]] == gold[ewb_addr[AW-1:5]], "R7", "write-back data",
             mem_a[ewb_addr[AW-1:5]], gold[ewb_addr[AW-1:5]]);
      end
      if (we) chk(mem_a[line] == mem_pre, "R4", "memory untouched by write", mem_a[line], mem_pre);
      if (ehit) begin
         exp_hits++;
         if (we) mdirty[st][way] = 1'b1;
      end else begin
         exp_miss++;
         mtag[st][way] = tg;
         mval[st][way] = 1'b1;
         mdirty[st][way] = we;
         mptr[st] = (mptr[st] + 1) % NW;
      end
   endtask

   function automatic logic [AW-1:0] mk(input int tg, input int st, input int off);
      return {9'(tg), 2'(st), 5'(off)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < NLINES; i++) begin
         for (int k = 0; k < LB; k++) mem_a[i][k*8 +: 8] = 8'((i * 7 + k * 13 + 5) & 255);
         gold[i] = mem_a[i];
      end
      for (int s = 0; s < NS; s++) begin
         mptr[s] = 0;
         for (int w = 0; w < NW; w++) begin
            mval[s][w] = 1'b0; mdirty[s][w] = 1'b0; mtag[s][w] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!up_busy, "R1", "busy after reset", LW'(up_busy), LW'(0));
      chk(!up_done, "R1", "done after reset", LW'(up_done), LW'(0));
      chk(!mem_rd_req && !mem_wr_req, "R1", "memory idle after reset",
          LW'({mem_rd_req, mem_wr_req}), LW'(0));
      // R1 cold miss, R2 hits on same line
      access(1'b0, mk(0, 2, 0), 8'h00);
      access(1'b0, mk(0, 2, 0), 8'h00);
      access(1'b0, mk(0, 2, 3), 8'h00);
      // R6 FIFO order with hits that must not reorder
      for (int t = 1; t <= 8; t++) access(1'b0, mk(t, 1, 0), 8'h00);
      for (int k = 0; k < 3; k++) access(1'b0, mk(1, 1, 4), 8'h00);
      access(1'b0, mk(9, 1, 0), 8'h00);
      access(1'b0, mk(2, 1, 0), 8'h00);
      access(1'b0, mk(1, 1, 0), 8'h00);
      access(1'b0, mk(2, 1, 0), 8'h00);
      // R4/R5 write-allocate then dirty hit, R7 dirty eviction
      access(1'b1, mk(3, 2, 7), 8'h5A);
      access(1'b0, mk(3, 2, 0), 8'h00);
      access(1'b1, mk(3, 2, 31), 8'hC3);
      for (int t = 10; t < 19; t++) access(1'b0, mk(t, 2, 0), 8'h00);
      access(1'b0, mk(3, 2, 0), 8'h00);
      // R7 clean evictions only
      for (int t = 20; t < 30; t++) access(1'b0, mk(t, 3, 1), 8'h00);
      // sweep with a small tag pool per set
      for (int n = 0; n < 1500; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         access(lf[0] & lf[5], mk(int'(lf[11:8]) % 11 + 40, int'(lf[3:2]), int'(lf[15:11])),
                lf[7:0] ^ lf[15:8]);
      end
      // R3 totals
      chk(ab_cnt == exp_hits, "R3", "total cancelled reads", LW'(ab_cnt), LW'(exp_hits));
      chk(rd_cnt == exp_miss, "R3", "total used reads", LW'(rd_cnt), LW'(exp_miss));
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule